// File: doc/BRIEF.md
# Accumulator-Based 8-Bit Processor

This block is a small multicycle processor. Register R0 doubles as the accumulator. Code and data share one 256-byte memory with a synchronous read port. The core fetches one opcode byte per instruction and, when the instruction needs one, a second operand byte. It then performs one of a fixed set of operations: arithmetic and logic between the accumulator and a memory byte, moves among registers, immediates and memory, register shifts, jumps, a branch on the accumulator sign, no-op and halt.

The memory is external. The core presents an address every cycle, drives write data and a write enable for stores, and takes read data one clock edge after each address. Each memory read therefore costs one wait state in the control sequence. A program runs from address 0 after reset and ends with a halt, which the core reports on its halted output until the next reset.

The opcode byte uses the high nibble for the operation, bits [3:2] for the destination register and bits [1:0] for the source register. The encodings are: 0x0 NOP, 0x1 ADD, 0x2 SUB, 0x3 XOR, 0x4 AND, 0x5 ADR, 0x6 MVI, 0x7 MVD, 0x8 MOV, 0x9 LDA, 0xA STA, 0xB BRN, 0xC JMP, 0xD SHR, 0xE SHL. The full byte 0xF0 is HALT.

Top module: `acc_cpu`

## Requirements
- R1: A synchronous reset clears the program counter and R0..R3 to 0. While rst is high, mem_addr is 0, mem_we is 0 and halted is 0. After release, the first fetch reads address 0.
- R2: ADD/SUB/XOR/AND X (high nibble 0x1/0x2/0x3/0x4, then operand byte X) replace R0 with R0+m, R0-m, R0^m or R0&m, where m is the byte at X. Add and subtract wrap modulo 256.
- R3: LDA X (0x9 nibble) loads the byte at X into R0. STA X (0xA nibble) writes R0 to address X with mem_we high for one cycle.
- R4: MVI (0x6 nibble, then an immediate byte) loads the immediate into the register named by bits [3:2]. MVD (0x7 nibble, then address X) loads the byte at X into that register.
- R5: MOV (0x8 nibble) copies the register named by bits [1:0] into the register named by bits [3:2]. ADR (0x5 nibble) writes dst+src modulo 256 into dst. All other registers keep their values.
- R6: SHR (0xD nibble) and SHL (0xE nibble) shift the register named by bits [3:2] by one bit toward the LSB or the MSB, filling the vacated bit with 0.
- R7: JMP X (0xC nibble) continues execution at address X, and the byte pair after the JMP is not executed.
- R8: BRN X (0xB nibble) continues at X when R0 bit 7 is 1. Otherwise it continues with the instruction after its operand byte.
- R9: HALT (byte 0xF0) raises halted. halted stays high until reset, and no memory write occurs in that time.
- R10: NOP (0x00) and any undefined opcode (0xF1..0xFF) are single-byte instructions that change no register or memory.
- R11: Counted in rising edges, a no-operand instruction takes 3 cycles, an immediate, jump or store instruction takes 5, and a memory-read instruction takes 7. A HALT at address 0 raises halted on the 3rd rising edge after reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 8 | Memory address for fetch, read or write |
| mem_wdata | output | 8 | Store data (the accumulator) |
| mem_rdata | input | 8 | Read data, valid one edge after the address |
| mem_we | output | 1 | Write strobe for a store |
| halted | output | 1 | High once HALT has executed |

## Verification
The arithmetic group uses operand pairs where 0xF0 plus 0x25 overflows and 0x25 minus 0xF0 borrows, with both subtraction orders. This separates wrapping from saturation and shows which operand is the minuend. The move tests fill each register with a distinct value and then read them back through R0. A swapped destination or source field, or a write to the wrong register, would show up as a wrong stored byte. The branch program runs BRN once with bit 7 set and once with it clear, and places guard stores after a JMP and at the not-taken target, so taken and fall-through paths are told apart. Cycle counts for NOP, MVI and ADD programs catch a missing or extra wait state.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int DW  = 8;
  localparam int AW  = 8;
  localparam int RIW = 2;
  localparam int NREG = 1 << RIW;

  typedef enum logic [3:0] {
    OP_NOP = 4'h0, OP_ADD = 4'h1, OP_SUB = 4'h2, OP_XOR = 4'h3,
    OP_AND = 4'h4, OP_ADR = 4'h5, OP_MVI = 4'h6, OP_MVD = 4'h7,
    OP_MOV = 4'h8, OP_LDA = 4'h9, OP_STA = 4'hA, OP_BRN = 4'hB,
    OP_JMP = 4'hC, OP_SHR = 4'hD, OP_SHL = 4'hE, OP_HALT = 4'hF
  } op_e;

  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_OPF, S_OPW, S_MRD, S_MWT, S_EXEC, S_HALT
  } state_e;

  // 0xF0 is HALT; other 0xF_ codes are treated as no-ops
  function automatic op_e decode_op(input logic [DW-1:0] b);
    if (b[7:4] == 4'hF && b[3:0] != 4'h0) return OP_NOP;
    return op_e'(b[7:4]);
  endfunction

  function automatic logic needs_opnd(input op_e op);
    return op inside {OP_ADD, OP_SUB, OP_XOR, OP_AND, OP_MVI, OP_MVD,
                      OP_LDA, OP_STA, OP_BRN, OP_JMP};
  endfunction

  function automatic logic reads_mem(input op_e op);
    return op inside {OP_ADD, OP_SUB, OP_XOR, OP_AND, OP_MVD, OP_LDA};
  endfunction

  function automatic logic writes_reg(input op_e op);
    return op inside {OP_ADD, OP_SUB, OP_XOR, OP_AND, OP_ADR, OP_MVI,
                      OP_MVD, OP_MOV, OP_LDA, OP_SHR, OP_SHL};
  endfunction

  function automatic logic acc_dest(input op_e op);
    return op inside {OP_ADD, OP_SUB, OP_XOR, OP_AND, OP_LDA};
  endfunction

  function automatic logic [DW-1:0] alu_fn(input op_e op,
                                           input logic [DW-1:0] a,
                                           input logic [DW-1:0] b);
    case (op)
      OP_ADD, OP_ADR: return a + b;
      OP_SUB:         return a - b;
      OP_XOR:         return a ^ b;
      OP_AND:         return a & b;
      OP_SHR:         return a >> 1;
      OP_SHL:         return a << 1;
      default:        return b;
    endcase
  endfunction
endpackage

// File: rtl/cpu_regfile.sv
module cpu_regfile
  import acc_cpu_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [RIW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [RIW-1:0] raddr_a,
  input  logic [RIW-1:0] raddr_b,
  output logic [DW-1:0]  rdata_a,
  output logic [DW-1:0]  rdata_b,
  output logic [DW-1:0]  acc
);
  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst) regs[i] <= '0;
      else if (we && waddr == RIW'(i)) regs[i] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
  assign acc     = regs[0];

  for (genvar g = 0; g < NREG; g++) begin : g_hold
    // R5: a register not addressed by the write keeps its value
    a_r5_reg_hold: assert property (@(posedge clk) disable iff (rst)
      !(we && waddr == RIW'(g)) |=> $stable(regs[g]));
  end
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import acc_cpu_pkg::*;
(
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  assign y = alu_fn(op, a, b);
endmodule

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           acc_neg,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_we,
  output op_e            op,
  output logic [RIW-1:0] dst,
  output logic [RIW-1:0] src,
  output logic [DW-1:0]  opnd,
  output logic           rf_we,
  output logic           halted
);
  state_e        state, nxt;
  logic [DW-1:0] ir;
  logic [AW-1:0] pc;

  // named internal events
  logic pc_step, exec, br_take, undef_exec;

  assign op         = decode_op(ir);
  assign dst        = ir[3:2];
  assign src        = ir[1:0];
  assign exec       = (state == S_EXEC);
  assign pc_step    = (state == S_FETCH) || (state == S_OPF);
  assign br_take    = exec && (op == OP_JMP || (op == OP_BRN && acc_neg));
  assign undef_exec = exec && ir[7:4] == 4'hF && ir[3:0] != 4'h0;

  always_comb begin
    nxt = state;
    case (state)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: nxt = needs_opnd(decode_op(mem_rdata)) ? S_OPF : S_EXEC;
      S_OPF:    nxt = S_OPW;
      S_OPW:    nxt = reads_mem(op) ? S_MRD : S_EXEC;
      S_MRD:    nxt = S_MWT;
      S_MWT:    nxt = S_EXEC;
      S_EXEC:   nxt = (op == OP_HALT) ? S_HALT : S_FETCH;
      S_HALT:   nxt = S_HALT;
      default:  nxt = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_FETCH;
      pc    <= '0;
      ir    <= '0;
      opnd  <= '0;
    end else begin
      state <= nxt;
      if (pc_step)      pc <= pc + 1'b1;
      else if (br_take) pc <= AW'(opnd);
      if (state == S_DECODE) ir <= mem_rdata;
      if (state == S_OPW || state == S_MWT) opnd <= mem_rdata;
    end
  end

  assign rf_we    = exec && writes_reg(op);
  assign mem_we   = exec && (op == OP_STA);
  assign mem_addr = (state == S_MRD || mem_we) ? AW'(opnd) : pc;
  assign halted   = (state == S_HALT);

  // R9: halt is sticky and silent
  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
  a_r9_no_write_halted: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);
  // R8: a not-taken branch leaves the program counter alone
  a_r8_brn_fallthrough: assert property (@(posedge clk) disable iff (rst)
    (exec && op == OP_BRN && !acc_neg) |=> (pc == $past(pc)));
  // R7: a jump lands on its operand
  a_r7_jump_target: assert property (@(posedge clk) disable iff (rst)
    (exec && op == OP_JMP) |=> (pc == $past(AW'(opnd))));
  // R11: each byte fetch advances the program counter by one
  a_r11_fetch_step: assert property (@(posedge clk) disable iff (rst)
    pc_step |=> (pc == $past(pc) + 1'b1));
  // R10: an undefined code returns to fetch and does not halt
  a_r10_undef_continues: assert property (@(posedge clk) disable iff (rst)
    undef_exec |=> (state == S_FETCH));
  // R1: the first cycle after reset fetches address 0 without writing
  a_r1_reset_fetch: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_addr == '0 && !mem_we && !halted));
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic          halted
);
  op_e            op;
  logic [RIW-1:0] dst, src, waddr;
  logic [DW-1:0]  opnd, acc, rd_a, rd_b, alu_a, alu_b, alu_y;
  logic           rf_we;

  cpu_ctrl u_ctrl (
    .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .acc_neg(acc[DW-1]),
    .mem_addr(mem_addr), .mem_we(mem_we), .op(op), .dst(dst), .src(src),
    .opnd(opnd), .rf_we(rf_we), .halted(halted)
  );

  assign waddr = acc_dest(op) ? '0 : dst;
  assign alu_a = acc_dest(op) ? acc : rd_a;
  assign alu_b = (op == OP_ADR || op == OP_MOV) ? rd_b : opnd;

  cpu_regfile u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(waddr), .wdata(alu_y),
    .raddr_a(dst), .raddr_b(src), .rdata_a(rd_a), .rdata_b(rd_b), .acc(acc)
  );

  cpu_alu u_alu (.op(op), .a(alu_a), .b(alu_b), .y(alu_y));

  assign mem_wdata = acc;

  // R6: shifts bring in a zero bit
  a_r6_shl_zero_fill: assert property (@(posedge clk) disable iff (rst)
    (rf_we && op == OP_SHL) |-> (alu_y[0] == 1'b0));
  a_r6_shr_zero_fill: assert property (@(posedge clk) disable iff (rst)
    (rf_we && op == OP_SHR) |-> (alu_y[DW-1] == 1'b0));
  // R3: a store drives the accumulator value of the cycle it happens in
  a_r3_store_data: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (u_rf.acc == $past(mem_wdata)));
endmodule

// File: tb/tb_acc_cpu.sv
module tb_acc_cpu;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       mem_we, halted;
  logic [7:0] mem [256];
  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .halted(halted)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'hF0;
    for (int i = 8'hA0; i < 8'hA8; i++) mem[i] = 8'hEE;
  endtask

  task automatic wr(input int a, input int v);
    mem[a] = v[7:0];
  endtask

  // reset, release, count rising edges until halted
  task automatic run(output int n);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    n = 0;
    while (!halted && n < 3000) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
  endtask

  task automatic t_alu();
    int n;
    clear_mem();
    wr(8'h80, 8'hF0); wr(8'h81, 8'h25);
    wr(0, 8'h90); wr(1, 8'h80); wr(2, 8'h10); wr(3, 8'h81); wr(4, 8'hA0); wr(5, 8'hA0);
    wr(6, 8'h90); wr(7, 8'h80); wr(8, 8'h20); wr(9, 8'h81); wr(10, 8'hA0); wr(11, 8'hA1);
    wr(12, 8'h90); wr(13, 8'h81); wr(14, 8'h20); wr(15, 8'h80); wr(16, 8'hA0); wr(17, 8'hA2);
    wr(18, 8'h90); wr(19, 8'h80); wr(20, 8'h30); wr(21, 8'h81); wr(22, 8'hA0); wr(23, 8'hA3);
    wr(24, 8'h90); wr(25, 8'h80); wr(26, 8'h40); wr(27, 8'h81); wr(28, 8'hA0); wr(29, 8'hA4);
    run(n);
    chk("R9 halted after alu program", halted, 1);
    chk("R2 ADD wraps", mem[8'hA0], (8'hF0 + 8'h25) % 256);
    chk("R2 SUB", mem[8'hA1], 8'hF0 - 8'h25);
    chk("R2 SUB borrow wraps", mem[8'hA2], (256 + 8'h25 - 8'hF0) % 256);
    chk("R2 XOR", mem[8'hA3], 8'hD5);
    chk("R2 AND", mem[8'hA4], 8'h20);
    chk("R3 STA untouched neighbour", mem[8'hA5], 8'hEE);
  endtask

  task automatic t_moves();
    int n;
    clear_mem();
    wr(8'h80, 8'hF0);
    wr(0, 8'h64); wr(1, 8'h37);   // MVI R1,#37
    wr(2, 8'h78); wr(3, 8'h80);   // MVD R2,[80]
    wr(4, 8'h8D);                 // MOV R3,R1
    wr(5, 8'h5E);                 // ADR R3,R2
    wr(6, 8'h83); wr(7, 8'hA0); wr(8, 8'hA0);
    wr(9, 8'h82); wr(10, 8'hA0); wr(11, 8'hA1);
    wr(12, 8'h81); wr(13, 8'hA0); wr(14, 8'hA2);
    wr(15, 8'h60); wr(16, 8'h5A); wr(17, 8'hA0); wr(18, 8'hA3);
    wr(19, 8'h90); wr(20, 8'h80); wr(21, 8'hA0); wr(22, 8'hA4); // LDA, STA
    run(n);
    chk("R5 ADR dst+src wraps", mem[8'hA0], (8'h37 + 8'hF0) % 256);
    chk("R4 MVD into R2", mem[8'hA1], 8'hF0);
    chk("R5 MOV source kept, R1", mem[8'hA2], 8'h37);
    chk("R4 MVI into R0", mem[8'hA3], 8'h5A);
    chk("R3 LDA then STA", mem[8'hA4], 8'hF0);
  endtask

  task automatic t_shift();
    int n;
    clear_mem();
    wr(0, 8'h68); wr(1, 8'h81); wr(2, 8'hD8); wr(3, 8'h82); wr(4, 8'hA0); wr(5, 8'hA0);
    wr(6, 8'h64); wr(7, 8'h81); wr(8, 8'hE4); wr(9, 8'h81); wr(10, 8'hA0); wr(11, 8'hA1);
    run(n);
    chk("R6 SHR zero fill", mem[8'hA0], 8'h81 >> 1);
    chk("R6 SHL zero fill", mem[8'hA1], (8'h81 << 1) % 256);
  endtask

  task automatic t_branch();
    int n;
    clear_mem();
    wr(8'h00, 8'h60); wr(8'h01, 8'h80); wr(8'h02, 8'hB0); wr(8'h03, 8'h20);
    wr(8'h04, 8'h60); wr(8'h05, 8'h11); wr(8'h06, 8'hA0); wr(8'h07, 8'hA0);
    wr(8'h20, 8'h60); wr(8'h21, 8'h22); wr(8'h22, 8'hA0); wr(8'h23, 8'hA1);
    wr(8'h24, 8'h60); wr(8'h25, 8'h01); wr(8'h26, 8'hB0); wr(8'h27, 8'h40);
    wr(8'h28, 8'h60); wr(8'h29, 8'h33); wr(8'h2A, 8'hA0); wr(8'h2B, 8'hA2);
    wr(8'h2C, 8'hC0); wr(8'h2D, 8'h50); wr(8'h2E, 8'hA0); wr(8'h2F, 8'hA4);
    wr(8'h40, 8'h60); wr(8'h41, 8'h99); wr(8'h42, 8'hA0); wr(8'h43, 8'hA0);
    wr(8'h50, 8'h60); wr(8'h51, 8'h44); wr(8'h52, 8'hA0); wr(8'h53, 8'hA3);
    run(n);
    chk("R8 BRN taken skips fallthrough", mem[8'hA0], 8'hEE);
    chk("R8 BRN taken target ran", mem[8'hA1], 8'h22);
    chk("R8 BRN not taken falls through", mem[8'hA2], 8'h33);
    chk("R7 JMP target ran", mem[8'hA3], 8'h44);
    chk("R7 JMP skipped next store", mem[8'hA4], 8'hEE);
  endtask

  task automatic t_halt_undef();
    int n;
    int bad;
    logic [7:0] a0;
    clear_mem();
    wr(0, 8'h00); wr(1, 8'hF5); wr(2, 8'hFF); wr(3, 8'h60); wr(4, 8'h07);
    wr(5, 8'hA0); wr(6, 8'hA0); wr(7, 8'hF0); wr(8, 8'hA0); wr(9, 8'hA1);
    run(n);
    chk("R10 undefined codes act as NOP", mem[8'hA0], 8'h07);
    chk("R9 halted raised", halted, 1);
    bad = 0;
    a0 = mem_addr;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mem_we || !halted || mem_addr != a0) bad++;
    end
    chk("R9 stays halted with no write", bad, 0);
    chk("R9 store after HALT not done", mem[8'hA1], 8'hEE);
  endtask

  task automatic t_reset();
    int n;
    // leave registers non-zero, then reset and read them back
    clear_mem();
    wr(0, 8'h64); wr(1, 8'h11); wr(2, 8'h68); wr(3, 8'h22);
    wr(4, 8'h6C); wr(5, 8'h33); wr(6, 8'h60); wr(7, 8'h44);
    run(n);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 reset mem_addr", mem_addr, 0);
    chk("R1 reset mem_we", mem_we, 0);
    chk("R1 reset clears halted", halted, 0);
    clear_mem();
    wr(0, 8'hA0); wr(1, 8'hA0);
    wr(2, 8'h81); wr(3, 8'hA0); wr(4, 8'hA1);
    wr(5, 8'h82); wr(6, 8'hA0); wr(7, 8'hA2);
    wr(8, 8'h83); wr(9, 8'hA0); wr(10, 8'hA3);
    run(n);
    chk("R1 R0 cleared", mem[8'hA0], 0);
    chk("R1 R1 cleared", mem[8'hA1], 0);
    chk("R1 R2 cleared", mem[8'hA2], 0);
    chk("R1 R3 cleared", mem[8'hA3], 0);
  endtask

  task automatic t_timing();
    int n;
    clear_mem();
    run(n);
    chk("R11 HALT at 0 edges", n, 3);
    clear_mem(); wr(0, 8'h00);
    run(n);
    chk("R11 NOP then HALT edges", n, 6);
    clear_mem(); wr(0, 8'h60); wr(1, 8'h01);
    run(n);
    chk("R11 MVI then HALT edges", n, 8);
    clear_mem(); wr(0, 8'h10); wr(1, 8'h80);
    run(n);
    chk("R11 ADD then HALT edges", n, 10);
    clear_mem(); wr(0, 8'hA0); wr(1, 8'hA0);
    run(n);
    chk("R11 STA then HALT edges", n, 8);
  endtask

  initial begin
    clear_mem();
    t_reset();
    t_alu();
    t_moves();
    t_shift();
    t_branch();
    t_halt_undef();
    t_timing();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule